// File: doc/BRIEF.md
# Accumulator ALU with Packed-Decimal Arithmetic

This is a purely combinational arithmetic and logic unit for a small accumulator-style processor. The sequencer supplies an operation code, the register value (accumulator, or an index register for compares), the operand, and the current carry and decimal-mode flags. The unit returns the result together with new negative (N), zero (Z), carry (C) and overflow (V) values. Each flag comes with its own write-enable, so the flag register outside the unit keeps any flag that the operation does not define.

Addition and subtraction work either in plain binary or in packed BCD. In BCD mode the unit first forms the ordinary binary sum and then adds a correction term, derived from the nibble carries, that brings each digit back into 0..9. N, Z and V always describe the binary sum before that correction; only the result and the carry reflect it. The register file, memory writeback and instruction sequencing are not part of this unit.

Top module: `accu_alu`

## Requirements
- R1: Add (op 0) forms s = reg + opnd + c_in. In binary mode res = s mod 2^W, C = bit W of s, N = s[W-1], Z = (s mod 2^W == 0), V = bit W-1 of ((s^reg)&(s^opnd)); all four write-enables are high.
- R2: Add with d_in=1 adds the correction 3 × ((((s + 0x66..) ^ reg ^ opnd) >> 3) & 0x22..) to s; res is the low W bits of the corrected sum and C is set when the corrected sum is at least 2^W (e.g. 0x99+0x01 gives 0x00 with C=1).
- R3: In decimal mode N and Z come from the uncorrected binary sum, not the corrected result (0x99+0x01 gives N=1, Z=0 while res is 0x00).
- R4: Subtract (op 1) in binary mode runs the add path with the operand inverted: 0x80 − 0x01 with c_in=1 gives 0x7F, C=1, V=1.
- R5: Subtract with d_in=1 also takes 0x66.. off the inverted operand (modulo 2^W) before the add and correction; 0x46−0x12 gives 0x34 with C=1 and 0x12−0x21 gives 0x91 with C=0.
- R6: Compare (op 2) sets C when reg ≥ opnd as unsigned numbers and takes N and Z from the W-bit difference; V's write-enable is low and res equals reg.
- R7: Bit test (op 3) sets Z when reg & opnd is zero and copies opnd bits W-1 and W-2 into N and V; C's write-enable is low and res equals reg.
- R8: AND (op 4), OR (op 5) and XOR (op 6) of reg and opnd update only N and Z: N = res[W-1], Z = (res == 0).
- R9: Shift left (op 7) and logical shift right (op 8) act on opnd; the bit shifted out goes to C and a zero is shifted in; C, N and Z are written, V is not.
- R10: Rotate left (op 9) moves c_in into bit 0 and rotate right (op 10) moves c_in into bit W-1; the bit shifted out goes to C; V is not written.
- R11: Load (op 11) passes opnd to res and writes only N and Z.
- R12: Op codes 12 to 15 raise no write-enable and pass reg to res.
- R13: d_in has no effect on any operation other than add and subtract.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| reg_i | input | W | Accumulator or index register value |
| opnd_i | input | W | Operand |
| c_i | input | 1 | Incoming carry flag |
| d_i | input | 1 | Decimal mode flag |
| res_o | output | W | Result |
| n_o | output | 1 | New negative flag |
| n_we_o | output | 1 | Negative flag write-enable |
| z_o | output | 1 | New zero flag |
| z_we_o | output | 1 | Zero flag write-enable |
| c_o | output | 1 | New carry flag |
| c_we_o | output | 1 | Carry flag write-enable |
| v_o | output | 1 | New overflow flag |
| v_we_o | output | 1 | Overflow flag write-enable |

## Verification
The bench builds the unit with the default W of 8, which is the width at which the decimal correction constants become 0x66 and 0x22 and every expected value can be worked out by hand in two-digit BCD. At that width the directed cases reach the digit overflow from 99 to 00 with carry, the borrow case of a decimal subtract, the signed overflow corners of binary add and subtract, and the split between the uncorrected N/Z flags and the corrected result.

// File: rtl/accu_alu.sv
module accu_alu #(
  parameter int W = 8
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] reg_i,
  input  logic [W-1:0] opnd_i,
  input  logic         c_i,
  input  logic         d_i,
  output logic [W-1:0] res_o,
  output logic         n_o,
  output logic         n_we_o,
  output logic         z_o,
  output logic         z_we_o,
  output logic         c_o,
  output logic         c_we_o,
  output logic         v_o,
  output logic         v_we_o
);

  localparam int NIB = W / 4;
  localparam int SW  = W + 2;
  localparam logic [W-1:0] SIXES = {NIB{4'h6}};
  localparam logic [W-1:0] TWOS  = {NIB{4'h2}};

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_CMP = 4'd2;
  localparam logic [3:0] OP_BIT = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4;
  localparam logic [3:0] OP_OR  = 4'd5;
  localparam logic [3:0] OP_XOR = 4'd6;
  localparam logic [3:0] OP_SHL = 4'd7;
  localparam logic [3:0] OP_SHR = 4'd8;
  localparam logic [3:0] OP_ROL = 4'd9;
  localparam logic [3:0] OP_ROR = 4'd10;
  localparam logic [3:0] OP_LD  = 4'd11;

  logic         is_sub;
  logic [W-1:0] inv_opnd;
  logic [W-1:0] addend;
  logic [SW-1:0] bin_sum;
  logic [SW-1:0] probe;
  logic [SW-1:0] fix;
  logic [SW-1:0] dec_sum;
  logic [SW-1:0] fin_sum;
  logic [W-1:0] diff;
  logic [W-1:0] logic_res;
  logic [W-1:0] shf_res;
  logic         shf_out;

  assign is_sub   = (op_i == OP_SUB);
  assign inv_opnd = ~opnd_i;
  assign addend   = is_sub ? (d_i ? inv_opnd - SIXES : inv_opnd) : opnd_i;
  assign bin_sum  = SW'(reg_i) + SW'(addend) + SW'(c_i);

  assign probe   = bin_sum + SW'(SIXES);
  assign fix     = ((probe ^ SW'(reg_i) ^ SW'(addend)) >> 3) & SW'(TWOS);
  assign dec_sum = bin_sum + fix + (fix << 1);
  assign fin_sum = d_i ? dec_sum : bin_sum;

  assign diff = reg_i - opnd_i;

  always_comb begin
    case (op_i)
      OP_AND:  logic_res = reg_i & opnd_i;
      OP_OR:   logic_res = reg_i | opnd_i;
      default: logic_res = reg_i ^ opnd_i;
    endcase
  end

  always_comb begin
    case (op_i)
      OP_SHL:  begin shf_res = {opnd_i[W-2:0], 1'b0}; shf_out = opnd_i[W-1]; end
      OP_SHR:  begin shf_res = {1'b0, opnd_i[W-1:1]}; shf_out = opnd_i[0];   end
      OP_ROL:  begin shf_res = {opnd_i[W-2:0], c_i};  shf_out = opnd_i[W-1]; end
      default: begin shf_res = {c_i, opnd_i[W-1:1]};  shf_out = opnd_i[0];   end
    endcase
  end

  always_comb begin
    res_o  = reg_i;
    n_o    = 1'b0;
    z_o    = 1'b0;
    c_o    = 1'b0;
    v_o    = 1'b0;
    n_we_o = 1'b0;
    z_we_o = 1'b0;
    c_we_o = 1'b0;
    v_we_o = 1'b0;
    case (op_i)
      OP_ADD, OP_SUB: begin
        res_o  = fin_sum[W-1:0];
        n_o    = bin_sum[W-1];
        z_o    = (bin_sum[W-1:0] == '0);
        v_o    = ((bin_sum[W-1] ^ reg_i[W-1]) & (bin_sum[W-1] ^ addend[W-1]));
        c_o    = |fin_sum[SW-1:W];
        n_we_o = 1'b1;
        z_we_o = 1'b1;
        c_we_o = 1'b1;
        v_we_o = 1'b1;
      end
      OP_CMP: begin
        n_o    = diff[W-1];
        z_o    = (diff == '0);
        c_o    = (reg_i >= opnd_i);
        n_we_o = 1'b1;
        z_we_o = 1'b1;
        c_we_o = 1'b1;
      end
      OP_BIT: begin
        z_o    = ((reg_i & opnd_i) == '0);
        n_o    = opnd_i[W-1];
        v_o    = opnd_i[W-2];
        n_we_o = 1'b1;
        z_we_o = 1'b1;
        v_we_o = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_o  = logic_res;
        n_o    = logic_res[W-1];
        z_o    = (logic_res == '0);
        n_we_o = 1'b1;
        z_we_o = 1'b1;
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        res_o  = shf_res;
        n_o    = shf_res[W-1];
        z_o    = (shf_res == '0);
        c_o    = shf_out;
        n_we_o = 1'b1;
        z_we_o = 1'b1;
        c_we_o = 1'b1;
      end
      OP_LD: begin
        res_o  = opnd_i;
        n_o    = opnd_i[W-1];
        z_o    = (opnd_i == '0);
        n_we_o = 1'b1;
        z_we_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/accu_alu_chk.sv
module accu_alu_chk #(
  parameter int W = 8
) (
  input logic [3:0]   op_i,
  input logic [W-1:0] reg_i,
  input logic [W-1:0] opnd_i,
  input logic         c_i,
  input logic         d_i,
  input logic [W-1:0] res_o,
  input logic         n_o,
  input logic         n_we_o,
  input logic         z_o,
  input logic         z_we_o,
  input logic         c_o,
  input logic         c_we_o,
  input logic         v_o,
  input logic         v_we_o
);

  function automatic logic all_bcd(input logic [W-1:0] x);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < W / 4; k++)
      if (x[4*k +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  always_comb begin
    if (op_i == 4'd0 && d_i && all_bcd(reg_i) && all_bcd(opnd_i))
      p_bcd_digits_r2: assert (all_bcd(res_o)) else $error("decimal add left a non-BCD digit");
    if (op_i == 4'd2)
      p_cmp_carry_r6: assert (c_we_o && !v_we_o && c_o == (reg_i >= opnd_i) && res_o == reg_i)
        else $error("compare flags wrong");
    if (op_i == 4'd3)
      p_bit_copy_r7: assert (n_o == opnd_i[W-1] && v_o == opnd_i[W-2] && !c_we_o && res_o == reg_i)
        else $error("bit test flags wrong");
    if (op_i >= 4'd4 && op_i <= 4'd6)
      p_logic_nz_r8: assert (n_we_o && z_we_o && !c_we_o && !v_we_o && n_o == res_o[W-1] && z_o == (res_o == '0))
        else $error("logic op flag mask wrong");
    if (op_i >= 4'd7 && op_i <= 4'd10)
      p_shift_mask_r9: assert (c_we_o && !v_we_o && z_o == (res_o == '0)) else $error("shift flag mask wrong");
    if (op_i == 4'd9)
      p_rol_carry_r10: assert (res_o[0] == c_i && c_o == opnd_i[W-1]) else $error("rotate left wrong");
    if (op_i >= 4'd12)
      p_idle_r12: assert (!n_we_o && !z_we_o && !c_we_o && !v_we_o && res_o == reg_i)
        else $error("unassigned op touched state");
  end

endmodule

bind accu_alu accu_alu_chk #(.W(W)) i_accu_alu_chk (
  .op_i(op_i), .reg_i(reg_i), .opnd_i(opnd_i), .c_i(c_i), .d_i(d_i),
  .res_o(res_o), .n_o(n_o), .n_we_o(n_we_o), .z_o(z_o), .z_we_o(z_we_o),
  .c_o(c_o), .c_we_o(c_we_o), .v_o(v_o), .v_we_o(v_we_o)
);

// File: tb/test_accu_alu.sv
module test_accu_alu;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [3:0]   op;
  logic [W-1:0] rv, mv;
  logic         ci, di;
  logic [W-1:0] res;
  logic n, nwe, z, zwe, c, cwe, v, vwe;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  accu_alu #(.W(W)) i_accu_alu (
    .op_i(op), .reg_i(rv), .opnd_i(mv), .c_i(ci), .d_i(di),
    .res_o(res), .n_o(n), .n_we_o(nwe), .z_o(z), .z_we_o(zwe),
    .c_o(c), .c_we_o(cwe), .v_o(v), .v_we_o(vwe)
  );

  task automatic apply(input logic [3:0] o, input logic [W-1:0] a, input logic [W-1:0] m,
                       input logic cin, input logic din);
    @(posedge clk);
    op = o; rv = a; mv = m; ci = cin; di = din;
    @(negedge clk);
  endtask

  // we and fl are ordered {N, Z, C, V}; flag values are compared only where enabled
  task automatic expect_out(input string req, input logic [W-1:0] er,
                            input logic [3:0] ewe, input logic [3:0] efl);
    logic [3:0] gwe, gfl;
    gwe = {nwe, zwe, cwe, vwe};
    gfl = {n, z, c, v} & ewe;
    checks++;
    if (res !== er || gwe !== ewe || gfl !== (efl & ewe)) begin
      fails++;
      $display("FAIL %s: res=%h we=%b flags=%b, expected res=%h we=%b flags=%b",
               req, res, gwe, gfl, er, ewe, efl & ewe);
    end
  endtask

  task automatic t_reset;
    apply(4'd0, 8'h00, 8'h00, 1'b0, 1'b0);
    expect_out("R1 reset", 8'h00, 4'b1111, 4'b0100);
  endtask

  task automatic t_add_bin;
    apply(4'd0, 8'h50, 8'h50, 1'b0, 1'b0); expect_out("R1 signed ovf", 8'hA0, 4'b1111, 4'b1001);
    apply(4'd0, 8'hFF, 8'h01, 1'b0, 1'b0); expect_out("R1 wrap", 8'h00, 4'b1111, 4'b0110);
    apply(4'd0, 8'h10, 8'h20, 1'b1, 1'b0); expect_out("R1 carry in", 8'h31, 4'b1111, 4'b0000);
  endtask

  task automatic t_add_dec;
    apply(4'd0, 8'h15, 8'h27, 1'b0, 1'b1); expect_out("R2 digit fix", 8'h42, 4'b1111, 4'b0000);
    apply(4'd0, 8'h99, 8'h01, 1'b0, 1'b1); expect_out("R3 99+1", 8'h00, 4'b1111, 4'b1010);
    apply(4'd0, 8'h58, 8'h46, 1'b1, 1'b1); expect_out("R2 58+46+1", 8'h05, 4'b1111, 4'b1011);
  endtask

  task automatic t_sub;
    apply(4'd1, 8'h05, 8'h03, 1'b1, 1'b0); expect_out("R4 small", 8'h02, 4'b1111, 4'b0010);
    apply(4'd1, 8'h80, 8'h01, 1'b1, 1'b0); expect_out("R4 ovf", 8'h7F, 4'b1111, 4'b0011);
    apply(4'd1, 8'h46, 8'h12, 1'b1, 1'b1); expect_out("R5 no borrow", 8'h34, 4'b1111, 4'b1010);
    apply(4'd1, 8'h12, 8'h21, 1'b1, 1'b1); expect_out("R5 borrow", 8'h91, 4'b1111, 4'b1001);
  endtask

  task automatic t_cmp;
    apply(4'd2, 8'h40, 8'h40, 1'b0, 1'b0); expect_out("R6 equal", 8'h40, 4'b1110, 4'b0110);
    apply(4'd2, 8'h10, 8'h20, 1'b1, 1'b0); expect_out("R6 less", 8'h10, 4'b1110, 4'b1000);
  endtask

  task automatic t_bit;
    apply(4'd3, 8'h0F, 8'hC0, 1'b0, 1'b0); expect_out("R7 disjoint", 8'h0F, 4'b1101, 4'b1101);
    apply(4'd3, 8'h01, 8'h01, 1'b1, 1'b0); expect_out("R7 overlap", 8'h01, 4'b1101, 4'b0000);
  endtask

  task automatic t_logic;
    apply(4'd4, 8'hF0, 8'h3C, 1'b0, 1'b0); expect_out("R8 and", 8'h30, 4'b1100, 4'b0000);
    apply(4'd5, 8'h00, 8'h00, 1'b1, 1'b0); expect_out("R8 or zero", 8'h00, 4'b1100, 4'b0100);
    apply(4'd6, 8'hFF, 8'h0F, 1'b0, 1'b0); expect_out("R8 xor", 8'hF0, 4'b1100, 4'b1000);
  endtask

  task automatic t_shift;
    apply(4'd7, 8'h00, 8'h81, 1'b0, 1'b0); expect_out("R9 shl", 8'h02, 4'b1110, 4'b0010);
    apply(4'd8, 8'h00, 8'h01, 1'b1, 1'b0); expect_out("R9 shr", 8'h00, 4'b1110, 4'b0110);
    apply(4'd8, 8'h00, 8'h80, 1'b1, 1'b0); expect_out("R9 shr zero in", 8'h40, 4'b1110, 4'b0000);
  endtask

  task automatic t_rot;
    apply(4'd9,  8'h00, 8'h80, 1'b1, 1'b0); expect_out("R10 rol", 8'h01, 4'b1110, 4'b0010);
    apply(4'd10, 8'h00, 8'h01, 1'b1, 1'b0); expect_out("R10 ror", 8'h80, 4'b1110, 4'b1010);
    apply(4'd10, 8'h00, 8'h02, 1'b0, 1'b0); expect_out("R10 ror c0", 8'h01, 4'b1110, 4'b0000);
  endtask

  task automatic t_load;
    apply(4'd11, 8'h55, 8'h00, 1'b1, 1'b0); expect_out("R11 zero", 8'h00, 4'b1100, 4'b0100);
    apply(4'd11, 8'h00, 8'h9A, 1'b0, 1'b0); expect_out("R11 neg", 8'h9A, 4'b1100, 4'b1000);
  endtask

  task automatic t_idle;
    for (int k = 12; k < 16; k++) begin
      apply(4'(k), 8'hA5, 8'h3C, 1'b1, 1'b1);
      expect_out("R12 unassigned", 8'hA5, 4'b0000, 4'b0000);
    end
  endtask

  task automatic t_dec_ignored;
    apply(4'd2, 8'h10, 8'h20, 1'b0, 1'b1); expect_out("R13 cmp", 8'h10, 4'b1110, 4'b1000);
    apply(4'd7, 8'h00, 8'h81, 1'b0, 1'b1); expect_out("R13 shl", 8'h02, 4'b1110, 4'b0010);
    apply(4'd6, 8'h99, 8'h09, 1'b0, 1'b1); expect_out("R13 xor", 8'h90, 4'b1100, 4'b1000);
  endtask

  initial begin
    op = '0; rv = '0; mv = '0; ci = 1'b0; di = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_add_bin();
    t_add_dec();
    t_sub();
    t_cmp();
    t_bit();
    t_logic();
    t_shift();
    t_rot();
    t_load();
    t_idle();
    t_dec_ignored();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule